// File: doc/BRIEF.md
# SD Card Clock Divider with Stop Gating

This block turns one source clock into two related outputs for an SD host controller. The first is a high-speed clock enable taken from a power-of-two pre-divider. The second is the SD card clock, a square wave that a divide-by-2 or divide-by-4 final stage builds from the pre-divider ticks. Both stages are set through one 32-bit control word. That word also holds one stop bit for each output. The overall ratio is the pre-divide times the final divide.

A host can load the control word directly. It can also select one of the preset divider entries by index, re-enable the clocks for the current setting, or force both clocks off. A status pin reports whether both clocks run. Divider and stop changes never cut an SD clock pulse short. A new setting takes effect only when the current SD period has ended, and a restarted clock always begins with its low phase. Every pin is a plain control or status signal, and no part of the block carries a data stream, so the block has no valid/ready handshake.

Top module: `sd_clk_gen`

## Requirements
- R1: After reset the control word reads 0x301: both stop bits set (bit 9 for the high-speed clock, bit 8 for the SD clock), pre-divider code 0 in bits 4:2 and final code 1 in bits 1:0. `sd_clk`, `hs_ce` and `clk_enabled` are low.
- R2: A write stores only bits 9, 8, 4:2 and 1:0, and all other bits read back as 0. `clk_enabled` is 1 exactly when bits 9 and 8 both read 0.
- R3: Pre-divider codes 0, 1, 2, 3 and 4 divide by N = 1, 2, 4, 8 and 16. Codes 5 to 7 act as code 4. While the high-speed clock runs, `hs_ce` is a one-cycle strobe every N source cycles, and it stays high continuously when N = 1.
- R4: Only bit 0 of the final field counts: 0 selects divide by 2 and 1 selects divide by 4, so codes 2 and 3 act as 0 and 1. `sd_clk` has a period of N×F source cycles with a high phase of N×F/2, which covers ratios from 2 to 64.
- R5: The two stop bits act independently. With bit 8 set, `sd_clk` stays low. With bit 9 set, `hs_ce` stays low. The SD clock keeps running while the high-speed clock is stopped.
- R6: A change of divider fields or stop bits made while `sd_clk` runs takes effect only after the falling edge that ends the current period. A high phase already under way completes at its old length, and the next low phase has the new length.
- R7: `dis_req` sets both stop bits. It wins over any write, selection or enable in the same cycle.
- R8: `sel_we` loads preset entry `sel_idx`. Entries 0–4 give final code 1 with pre code equal to the index. Entries 5–9 give final code 0 with pre code equal to the index minus 5. The SD stop bit is cleared, and the high-speed stop bit is set when the pre code is 2 or more. An index beyond the last entry changes nothing. A same-cycle `sel_we` overrides a write.
- R9: `en_req` leaves both divider fields as they are, clears the SD stop bit, and sets the high-speed stop bit only when the pre code is 2 or more. It overrides a same-cycle write or selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word to write |
| sel_we | input | 1 | Load a preset divider entry |
| sel_idx | input | 4 | Preset entry index |
| en_req | input | 1 | Re-enable the clocks for the current setting |
| dis_req | input | 1 | Force both stop bits |
| cfg_rdata | output | 32 | Control word readback |
| clk_enabled | output | 1 | Both clocks are enabled |
| sd_clk | output | 1 | Divided SD clock |
| hs_ce | output | 1 | High-speed clock enable strobe |

## Verification
The bench builds the block with its default parameters: a largest pre-divider code of 4 and the full ten-entry preset table, with no entry skipped. These values bring every ratio from 2 to 64 within reach, along with the reserved pre codes 5 to 7 and the out-of-range preset index 10. The bench measures the high and low phase lengths and the strobe spacing for each setting. It also checks a switch from the slowest ratio to the fastest made in the middle of a high phase, which shows that the old pulse completes at full length.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

  localparam int CTRL_W      = 32;
  localparam int HS_STOP_POS = 9;
  localparam int SD_STOP_POS = 8;
  localparam int PRE_LSB     = 2;
  localparam int PRE_W       = 3;
  localparam int FIN_LSB     = 0;
  localparam int FIN_W       = 2;
  localparam int HS_STOP_MIN = 2;   // pre codes from here upward stop the high-speed clock in presets

  typedef struct packed {
    logic             stop_hs;
    logic             stop_sd;
    logic [PRE_W-1:0] pre;
    logic [FIN_W-1:0] fin;
  } sdclk_cfg_t;

  localparam logic [CTRL_W-1:0] CTRL_MASK =
    (CTRL_W'(1) << HS_STOP_POS) | (CTRL_W'(1) << SD_STOP_POS) |
    (CTRL_W'((1 << PRE_W) - 1) << PRE_LSB) | (CTRL_W'((1 << FIN_W) - 1) << FIN_LSB);

  function automatic logic [CTRL_W-1:0] cfg_pack(sdclk_cfg_t c);
    logic [CTRL_W-1:0] w;
    w = '0;
    w[HS_STOP_POS] = c.stop_hs;
    w[SD_STOP_POS] = c.stop_sd;
    w[PRE_LSB +: PRE_W] = c.pre;
    w[FIN_LSB +: FIN_W] = c.fin;
    return w;
  endfunction

  function automatic sdclk_cfg_t cfg_unpack(logic [CTRL_W-1:0] w);
    sdclk_cfg_t c;
    c.stop_hs = w[HS_STOP_POS];
    c.stop_sd = w[SD_STOP_POS];
    c.pre     = w[PRE_LSB +: PRE_W];
    c.fin     = w[FIN_LSB +: FIN_W];
    return c;
  endfunction

  // Preset entry e: first run uses the /4 final stage, second run the /2 stage.
  function automatic sdclk_cfg_t preset_entry(int e, int max_pre);
    sdclk_cfg_t c;
    int p;
    if (e <= max_pre) begin
      p     = e;
      c.fin = FIN_W'(1);
    end else begin
      p     = e - (max_pre + 1);
      c.fin = FIN_W'(0);
    end
    c.pre     = PRE_W'(p);
    c.stop_sd = 1'b0;
    c.stop_hs = (p >= HS_STOP_MIN);
    return c;
  endfunction

endpackage

// File: rtl/sdclk_regs.sv
module sdclk_regs
  import sdclk_pkg::*;
#(
  parameter int MAX_PRE    = 4,
  parameter bit SKIP_FIRST = 1'b0,
  localparam int N_ENTRY   = 2 * (MAX_PRE + 1),
  localparam int IDX_W     = $clog2(N_ENTRY)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              sel_we,
  input  logic [IDX_W-1:0]  sel_idx,
  input  logic              en_req,
  input  logic              dis_req,
  output sdclk_cfg_t        cfg,
  output logic [CTRL_W-1:0] rd_data,
  output logic              enabled
);

  localparam int USABLE = N_ENTRY - (SKIP_FIRST ? 1 : 0);
  localparam int FIRST  = SKIP_FIRST ? 1 : 0;

  function automatic sdclk_cfg_t reset_cfg();
    sdclk_cfg_t c;
    c = preset_entry(FIRST, MAX_PRE);
    c.stop_hs = 1'b1;
    c.stop_sd = 1'b1;
    return c;
  endfunction

  sdclk_cfg_t cfg_q, cfg_d, sel_cfg;
  logic       sel_ok;

  always_comb begin
    sel_ok  = (int'(sel_idx) < USABLE);
    sel_cfg = preset_entry(int'(sel_idx) + FIRST, MAX_PRE);
  end

  // Later steps override earlier ones: write, preset, enable, disable.
  always_comb begin
    cfg_d = cfg_q;
    if (wr_en)
      cfg_d = cfg_unpack(wr_data);
    if (sel_we && sel_ok)
      cfg_d = sel_cfg;
    if (en_req) begin
      cfg_d.stop_sd = 1'b0;
      cfg_d.stop_hs = (int'(cfg_d.pre) >= HS_STOP_MIN);
    end
    if (dis_req) begin
      cfg_d.stop_sd = 1'b1;
      cfg_d.stop_hs = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= reset_cfg();
    else        cfg_q <= cfg_d;
  end

  assign cfg     = cfg_q;
  assign rd_data = cfg_pack(cfg_q);
  assign enabled = ~cfg_q.stop_hs & ~cfg_q.stop_sd;

  assert_dis_forces_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dis_req |=> (rd_data[HS_STOP_POS] && rd_data[SD_STOP_POS]));

  assert_en_clears_sd_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_req && !dis_req) |=> !rd_data[SD_STOP_POS]);

  assert_write_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sel_we && !en_req && !dis_req) |=> (rd_data == ($past(wr_data) & CTRL_MASK)));

endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider
  import sdclk_pkg::*;
#(
  parameter int MAX_PRE = 4,
  localparam int CNT_W  = (MAX_PRE < 1) ? 1 : MAX_PRE
) (
  input  logic       clk,
  input  logic       rst_n,
  input  sdclk_cfg_t cfg,
  output logic       sd_clk,
  output logic       hs_ce
);

  logic [PRE_W-1:0] act_pre;
  logic             act_fin;
  logic             sd_run, hs_run;
  logic [CNT_W-1:0] pcnt;
  logic             fph;
  logic [PRE_W-1:0] pre_clamped;
  logic [CNT_W-1:0] limit;
  logic             pend, toggle, upd;

  always_comb begin
    pre_clamped = (int'(cfg.pre) > MAX_PRE) ? PRE_W'(MAX_PRE) : cfg.pre;
    limit       = CNT_W'((1 << act_pre) - 1);
    pend        = (pcnt == limit);
    toggle      = sd_run && pend && (!act_fin || fph);
    // Settings are taken over only at a clean point of the output waveform.
    if (sd_run)      upd = toggle && sd_clk;
    else if (hs_run) upd = pend;
    else             upd = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_pre <= '0;
      act_fin <= 1'b0;
      sd_run  <= 1'b0;
      hs_run  <= 1'b0;
      pcnt    <= '0;
      fph     <= 1'b0;
      sd_clk  <= 1'b0;
    end else if (upd) begin
      act_pre <= pre_clamped;
      act_fin <= cfg.fin[0];
      sd_run  <= ~cfg.stop_sd;
      hs_run  <= ~cfg.stop_hs;
      pcnt    <= '0;
      fph     <= 1'b0;
      sd_clk  <= 1'b0;
    end else begin
      if (pend) begin
        pcnt <= '0;
        if (act_fin) fph <= ~fph;
      end else begin
        pcnt <= pcnt + CNT_W'(1);
      end
      if (toggle) sd_clk <= ~sd_clk;
    end
  end

  assign hs_ce = hs_run && pend;

  assert_sd_moves_only_running_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sd_clk) |-> $past(sd_run));

  assert_switch_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(act_pre) || !$stable(act_fin)) |-> ($fell(sd_clk) || !$past(sd_run)));

endmodule

// File: rtl/sd_clk_gen.sv
module sd_clk_gen
  import sdclk_pkg::*;
#(
  parameter int MAX_PRE    = 4,
  parameter bit SKIP_FIRST = 1'b0,
  localparam int IDX_W     = $clog2(2 * (MAX_PRE + 1))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CTRL_W-1:0] cfg_wdata,
  input  logic              sel_we,
  input  logic [IDX_W-1:0]  sel_idx,
  input  logic              en_req,
  input  logic              dis_req,
  output logic [CTRL_W-1:0] cfg_rdata,
  output logic              clk_enabled,
  output logic              sd_clk,
  output logic              hs_ce
);

  sdclk_cfg_t cfg;

  sdclk_regs #(.MAX_PRE(MAX_PRE), .SKIP_FIRST(SKIP_FIRST)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_data (cfg_wdata),
    .sel_we  (sel_we),
    .sel_idx (sel_idx),
    .en_req  (en_req),
    .dis_req (dis_req),
    .cfg     (cfg),
    .rd_data (cfg_rdata),
    .enabled (clk_enabled)
  );

  sdclk_divider #(.MAX_PRE(MAX_PRE)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg    (cfg),
    .sd_clk (sd_clk),
    .hs_ce  (hs_ce)
  );

endmodule

// File: tb/sd_clk_gen_test.sv
module sd_clk_gen_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        sel_we = 1'b0;
  logic [3:0]  sel_idx = '0;
  logic        en_req = 1'b0;
  logic        dis_req = 1'b0;
  logic [31:0] cfg_rdata;
  logic        clk_enabled, sd_clk, hs_ce;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  sd_clk_gen uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .sel_we(sel_we), .sel_idx(sel_idx), .en_req(en_req), .dis_req(dis_req),
    .cfg_rdata(cfg_rdata), .clk_enabled(clk_enabled), .sd_clk(sd_clk), .hs_ce(hs_ce)
  );

  // {pre[15:13], fin[12:11], expected high phase[10:5], expected strobe gap[4:0]}
  localparam int NVEC = 9;
  localparam logic [15:0] VEC [NVEC] = '{
    {3'd0, 2'd1, 6'd2,  5'd1},
    {3'd1, 2'd1, 6'd4,  5'd2},
    {3'd2, 2'd1, 6'd8,  5'd4},
    {3'd3, 2'd0, 6'd8,  5'd8},
    {3'd4, 2'd0, 6'd16, 5'd16},
    {3'd4, 2'd1, 6'd32, 5'd16},
    {3'd6, 2'd0, 6'd16, 5'd16},
    {3'd0, 2'd0, 6'd1,  5'd1},
    {3'd1, 2'd3, 6'd4,  5'd2}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cfg(input logic [31:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic pulse_sel(input logic [3:0] i);
    @(negedge clk); sel_we = 1'b1; sel_idx = i;
    @(negedge clk); sel_we = 1'b0;
  endtask

  task automatic pulse_en();
    @(negedge clk); en_req = 1'b1;
    @(negedge clk); en_req = 1'b0;
  endtask

  // Count negedge samples of the next full high phase and low phase.
  task automatic measure(output int hi, output int lo);
    int g;
    hi = 0; lo = 0; g = 0;
    while (sd_clk && g < 300) begin @(negedge clk); g++; end
    while (!sd_clk && g < 300) begin @(negedge clk); g++; end
    while (sd_clk && hi < 300) begin hi++; @(negedge clk); end
    while (!sd_clk && lo < 300) begin lo++; @(negedge clk); end
  endtask

  task automatic hs_gap(output int gap);
    int g;
    g = 0; gap = 0;
    while (!hs_ce && g < 300) begin @(negedge clk); g++; end
    do begin @(negedge clk); gap++; end while (!hs_ce && gap < 300);
  endtask

  task automatic count_high(input int n, output int sd_hits, output int hs_hits);
    sd_hits = 0; hs_hits = 0;
    repeat (n) begin
      @(negedge clk);
      if (sd_clk) sd_hits++;
      if (hs_ce) hs_hits++;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int hi, lo, gap, sdh, hsh;
    logic [31:0] v;

    cycles(4);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cfg_rdata == 32'h301, "R1 reset word", cfg_rdata, 32'h301);
    check(!sd_clk && !hs_ce && !clk_enabled, "R1 outputs low", {sd_clk, hs_ce, clk_enabled}, 0);
    count_high(50, sdh, hsh);
    check(sdh == 0 && hsh == 0, "R1 stays quiet", sdh + hsh, 0);

    // R2 masking, R5 both stopped
    write_cfg(32'hFFFF_FFFF);
    check(cfg_rdata == 32'h31F, "R2 masked readback", cfg_rdata, 32'h31F);
    check(!clk_enabled, "R2 status with stops", clk_enabled, 0);
    count_high(100, sdh, hsh);
    check(sdh == 0, "R5 sd held low", sdh, 0);
    check(hsh == 0, "R5 hs held low", hsh, 0);

    // R3 R4 ratio table
    for (int k = 0; k < NVEC; k++) begin
      v = (32'(VEC[k][15:13]) << 2) | 32'(VEC[k][12:11]);
      write_cfg(v);
      check(clk_enabled, "R2 status running", clk_enabled, 1);
      cycles(80);
      measure(hi, lo);
      check(hi == int'(VEC[k][10:5]), "R4 high phase", hi, VEC[k][10:5]);
      check(lo == int'(VEC[k][10:5]), "R4 low phase", lo, VEC[k][10:5]);
      hs_gap(gap);
      check(gap == int'(VEC[k][4:0]), "R3 strobe gap", gap, VEC[k][4:0]);
    end

    // R5 sd stopped, hs running
    write_cfg(32'h104);
    cycles(80);
    count_high(100, sdh, hsh);
    check(sdh == 0, "R5 sd stopped alone", sdh, 0);
    hs_gap(gap);
    check(gap == 2, "R5 hs runs alone", gap, 2);

    // R8 presets
    pulse_sel(4'd2);
    check(cfg_rdata == 32'h209, "R8 preset 2 word", cfg_rdata, 32'h209);
    check(!clk_enabled, "R8 preset 2 status", clk_enabled, 0);
    cycles(80);
    measure(hi, lo);
    check(hi == 8 && lo == 8, "R8 preset 2 phase", hi, 8);
    count_high(100, sdh, hsh);
    check(hsh == 0, "R5 hs stopped sd runs", hsh, 0);
    pulse_sel(4'd7);
    check(cfg_rdata == 32'h208, "R8 preset 7 word", cfg_rdata, 32'h208);
    pulse_sel(4'd5);
    check(cfg_rdata == 32'h000, "R8 preset 5 word", cfg_rdata, 32'h000);
    check(clk_enabled, "R8 preset 5 status", clk_enabled, 1);
    pulse_sel(4'd10);
    check(cfg_rdata == 32'h000, "R8 index out of range", cfg_rdata, 32'h000);

    // R7 disable and its priority
    @(negedge clk); dis_req = 1'b1;
    @(negedge clk); dis_req = 1'b0;
    check(cfg_rdata == 32'h300, "R7 disable word", cfg_rdata, 32'h300);
    check(!clk_enabled, "R7 status", clk_enabled, 0);
    cycles(80);
    count_high(100, sdh, hsh);
    check(sdh == 0 && hsh == 0, "R7 clocks quiet", sdh + hsh, 0);
    @(negedge clk); dis_req = 1'b1; cfg_we = 1'b1; cfg_wdata = 32'h004;
    @(negedge clk); dis_req = 1'b0; cfg_we = 1'b0;
    check(cfg_rdata == 32'h304, "R7 wins over write", cfg_rdata, 32'h304);

    // R9 enable
    pulse_en();
    check(cfg_rdata == 32'h004, "R9 enable low pre", cfg_rdata, 32'h004);
    check(clk_enabled, "R9 status", clk_enabled, 1);
    write_cfg(32'h310);
    pulse_en();
    check(cfg_rdata == 32'h210, "R9 enable high pre", cfg_rdata, 32'h210);

    // R6 switch from slowest to fastest in the middle of a high phase
    write_cfg(32'h011);
    cycles(150);
    while (sd_clk) @(negedge clk);
    while (!sd_clk) @(negedge clk);
    hi = 0;
    while (sd_clk && hi < 300) begin
      hi++;
      if (hi == 5) begin cfg_we = 1'b1; cfg_wdata = 32'h000; end
      if (hi == 6) cfg_we = 1'b0;
      @(negedge clk);
    end
    lo = 0;
    while (!sd_clk && lo < 300) begin lo++; @(negedge clk); end
    check(hi == 32, "R6 old high completes", hi, 32);
    check(lo == 1, "R6 new low phase", lo, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule